// File: doc/BRIEF.md
# Prioritized Local Interrupt Selector

This block decides which local interrupt a hart takes next. It combines the pending and enable vectors and splits the result by a delegation mask. Interrupts whose delegation bit is clear are handled at machine level. Interrupts whose delegation bit is set are handled at supervisor level.

Each half is then gated by a global enable. That enable follows from the current privilege level and from the machine and supervisor interrupt-enable status bits. The lowest-numbered interrupt that survives the gating wins.

The result is registered on one clock edge. It is a take flag plus the winning cause number, or a reserved no-interrupt code when nothing is eligible. Trap-entry logic downstream reads the two registered outputs and does not need to re-qualify them.

Top module: `irq_pick`

## Requirements
- R1: The candidate set is the bitwise AND of `irq_pend` and `irq_en`. A bit set in only one of the two vectors is never taken.
- R2: Machine-level handling is open when the privilege is not machine, or when it is machine and `m_gie` is 1.
- R3: Supervisor-level handling is open when the privilege is user, or when it is supervisor and `s_gie` is 1. It is never open at machine privilege.
- R4: A candidate with its `irq_dlg` bit at 0 is eligible only when machine-level handling is open. A candidate with its `irq_dlg` bit at 1 is eligible only when supervisor-level handling is open.
- R5: Among the eligible interrupts, the one with the lowest bit index is reported in `cause`. Bit 0 beats every other bit, and bit 15 can still win when it is alone.
- R6: With no eligible interrupt, `take` is 0 and `cause` holds the no-interrupt code, all ones. With the default width that code is 31. When `take` is 1, `cause` is never that code.
- R7: `cur_priv` encodes user as 0, supervisor as 1 and machine as 3. The value 2 behaves exactly like user.
- R8: `take` and `cause` reflect the inputs present at the previous rising clock edge. A synchronous active-high `rst` clears `take` and sets `cause` to the no-interrupt code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pend | input | NUM_IRQ | Pending interrupt bits |
| irq_en | input | NUM_IRQ | Per-interrupt enable bits |
| irq_dlg | input | NUM_IRQ | Delegation mask; 1 sends the bit to supervisor handling |
| cur_priv | input | 2 | Current privilege (0 user, 1 supervisor, 2 as user, 3 machine) |
| m_gie | input | 1 | Machine global interrupt enable |
| s_gie | input | 1 | Supervisor global interrupt enable |
| take | output | 1 | Registered: an interrupt should be taken |
| cause | output | $clog2(NUM_IRQ)+1 | Registered winning index, or all ones when none |

## Verification
The bench builds the block with the default of 16 interrupt lines, so cause values run from 0 to 15 and the no-interrupt code is 31. At that width a table of hand-worked vectors can reach both ends of the priority order. It also covers every privilege encoding, including the value 2, against each setting of the two global enables. Several hundred random mixes of pending, enable, delegation and status values are then compared with a model written from the requirements. This covers interactions between the machine and supervisor halves that the table does not list.

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int NUM_IRQ = 16
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_IRQ-1:0]             irq_pend,
  input  logic [NUM_IRQ-1:0]             irq_en,
  input  logic [NUM_IRQ-1:0]             irq_dlg,
  input  logic [1:0]                     cur_priv,
  input  logic                           m_gie,
  input  logic                           s_gie,
  output logic                           take,
  output logic [$clog2(NUM_IRQ):0]       cause
);
  localparam int CAUSE_W = $clog2(NUM_IRQ) + 1;
  localparam logic [CAUSE_W-1:0] NO_IRQ = '1;

  logic at_m, at_s, m_open, s_open;
  logic [NUM_IRQ-1:0] cand, elig;
  logic [CAUSE_W-1:0] pick;

  assign at_m   = (cur_priv == 2'd3);
  assign at_s   = (cur_priv == 2'd1);
  assign m_open = !at_m || m_gie;
  assign s_open = !(at_m || at_s) || (at_s && s_gie);

  assign cand = irq_pend & irq_en;
  assign elig = (cand & ~irq_dlg & {NUM_IRQ{m_open}})
              | (cand &  irq_dlg & {NUM_IRQ{s_open}});

  always_comb begin
    pick = NO_IRQ;
    for (int i = NUM_IRQ - 1; i >= 0; i--)
      if (elig[i]) pick = CAUSE_W'(i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      take  <= 1'b0;
      cause <= NO_IRQ;
    end else begin
      take  <= |elig;
      cause <= pick;
    end
  end

  a_r1_no_candidate: assert property (@(posedge clk) disable iff (rst)
    ((irq_pend & irq_en) == '0) |=> !take);

  a_r2_machine_locked: assert property (@(posedge clk) disable iff (rst)
    (cur_priv == 2'd3 && !m_gie) |=> !take);

  a_r3_machine_ignores_delegated: assert property (@(posedge clk) disable iff (rst)
    (cur_priv == 2'd3 && ((irq_pend & irq_en & ~irq_dlg) == '0)) |=> !take);

  a_r6_flag_cause_agree: assert property (@(posedge clk) disable iff (rst)
    take |-> (cause != NO_IRQ));

  a_r6_none_code: assert property (@(posedge clk) disable iff (rst)
    !take |-> (cause == NO_IRQ));

  a_r8_reset_clears: assert property (@(posedge clk)
    rst |=> (!take && cause == NO_IRQ));
endmodule

// File: tb/test_irq_pick.sv
module test_irq_pick;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] irq_pend, irq_en, irq_dlg;
  logic [1:0]  cur_priv;
  logic        m_gie, s_gie;
  logic        take;
  logic [4:0]  cause;

  int n_vec = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  irq_pick #(.NUM_IRQ(16)) i_irq_pick (
    .clk(clk), .rst(rst), .irq_pend(irq_pend), .irq_en(irq_en),
    .irq_dlg(irq_dlg), .cur_priv(cur_priv), .m_gie(m_gie), .s_gie(s_gie),
    .take(take), .cause(cause));

  // {pend, en, dlg, priv, mie, sie, exp_take, exp_cause}
  localparam int NV = 12;
  localparam logic [57:0] TBL [NV] = '{
    {16'h0000, 16'hFFFF, 16'h0000, 2'd3, 1'b1, 1'b1, 1'b0, 5'd31}, // R1 R6
    {16'h00A0, 16'h0080, 16'h0000, 2'd3, 1'b1, 1'b0, 1'b1, 5'd7 }, // R1
    {16'h0880, 16'hFFFF, 16'h0000, 2'd3, 1'b0, 1'b1, 1'b0, 5'd31}, // R2
    {16'h0880, 16'hFFFF, 16'h0000, 2'd1, 1'b0, 1'b0, 1'b1, 5'd7 }, // R2
    {16'h0222, 16'hFFFF, 16'h0222, 2'd3, 1'b1, 1'b1, 1'b0, 5'd31}, // R4 R3
    {16'h0222, 16'hFFFF, 16'h0222, 2'd1, 1'b1, 1'b0, 1'b0, 5'd31}, // R3
    {16'h0222, 16'hFFFF, 16'h0222, 2'd1, 1'b0, 1'b1, 1'b1, 5'd1 }, // R3
    {16'h0222, 16'hFFFF, 16'h0222, 2'd0, 1'b0, 1'b0, 1'b1, 5'd1 }, // R3
    {16'h0020, 16'hFFFF, 16'h0020, 2'd2, 1'b0, 1'b0, 1'b1, 5'd5 }, // R7
    {16'h0A02, 16'hFFFF, 16'h0002, 2'd1, 1'b0, 1'b0, 1'b1, 5'd9 }, // R4 R5
    {16'h8001, 16'h8001, 16'h0000, 2'd0, 1'b0, 1'b0, 1'b1, 5'd0 }, // R5
    {16'h8000, 16'h8000, 16'h8000, 2'd0, 1'b0, 1'b0, 1'b1, 5'd15}  // R5
  };

  function automatic logic [5:0] model(input logic [15:0] p, e, d,
                                       input logic [1:0] pv,
                                       input logic mi, si);
    logic mo, so;
    logic [15:0] el;
    mo = (pv != 2'd3) || mi;
    so = (pv == 2'd0) || (pv == 2'd2) || (pv == 2'd1 && si);
    el = (p & e & ~d & {16{mo}}) | (p & e & d & {16{so}});
    for (int i = 0; i < 16; i++)
      if (el[i]) return {1'b1, 5'(i)};
    return {1'b0, 5'd31};
  endfunction

  task automatic check(input string req, input logic et, input logic [4:0] ec);
    n_vec++;
    if (take !== et || cause !== ec) begin
      n_bad++;
      $display("FAIL %s: take=%0b cause=%0d expected take=%0b cause=%0d",
               req, take, cause, et, ec);
    end
  endtask

  task automatic apply(input logic [15:0] p, e, d, input logic [1:0] pv,
                       input logic mi, si);
    irq_pend = p; irq_en = e; irq_dlg = d; cur_priv = pv;
    m_gie = mi; s_gie = si;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [5:0] exp;
    rst = 1'b1;
    irq_pend = '0; irq_en = '0; irq_dlg = '0;
    cur_priv = 2'd3; m_gie = 1'b0; s_gie = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 reset state", 1'b0, 5'd31);
    rst = 1'b0;

    for (int k = 0; k < NV; k++) begin
      apply(TBL[k][57:42], TBL[k][41:26], TBL[k][25:10], TBL[k][9:8],
            TBL[k][7], TBL[k][6]);
      check($sformatf("R1-table row %0d", k), TBL[k][5], TBL[k][4:0]);
    end

    // R7: priv 2 matches priv 0 for all status combinations
    for (int s = 0; s < 4; s++) begin
      apply(16'h0101, 16'hFFFF, 16'h0001, 2'd2, s[0], s[1]);
      check("R7 priv2 as user", 1'b1, 5'd0);
    end

    // R8: latency - output follows inputs after one edge
    irq_pend = 16'h0400; irq_en = 16'hFFFF; irq_dlg = '0;
    cur_priv = 2'd0; m_gie = 1'b0; s_gie = 1'b0;
    @(posedge clk); #1;
    irq_pend = 16'h0000;
    @(negedge clk);
    check("R8 one-cycle capture", 1'b1, 5'd10);
    @(negedge clk);
    check("R8 follow next edge", 1'b0, 5'd31);

    // R8: synchronous reset with an eligible interrupt present
    irq_pend = 16'h0004;
    rst = 1'b1;
    @(negedge clk);
    check("R8 reset overrides", 1'b0, 5'd31);
    rst = 1'b0;
    @(negedge clk);
    check("R8 after reset", 1'b1, 5'd2);

    for (int r = 0; r < 400; r++) begin
      logic [15:0] p, e, d;
      logic [1:0]  pv;
      logic        mi, si;
      p  = 16'($urandom) & 16'($urandom);
      e  = 16'($urandom);
      d  = 16'($urandom);
      pv = 2'($urandom);
      mi = 1'($urandom);
      si = 1'($urandom);
      exp = model(p, e, d, pv, mi, si);
      apply(p, e, d, pv, mi, si);
      check("R2 R3 R4 R5 random", exp[5], exp[4:0]);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule